// File: doc/BRIEF.md
# Timing Wheel Event Scheduler

This block holds the pending events of a hardware event-driven logic simulator and hands them back one simulated time step at a time. An event is a signal number, a new value and the time at which the value takes effect. Near events go into a ring of time slots, one slot per time step inside a window that begins at the current simulated time. Each slot is a linked list of nodes taken from a shared node pool. Events further ahead wait in a small overflow store. They are moved onto the ring once the window reaches them.

A controller schedules events with `sch_valid`. It drains the current time with `pop_req` until `pend` drops, then issues `adv`. The scheduler keeps the last applied value of every signal. A popped entry that would not change its signal counts as a non-event: it is removed, but `pop_valid` stays low for it. On an advance the block raises `busy` and moves the time forward to the next time that holds work. When the ring is empty it jumps straight to the earliest overflow time. Before it finishes, it moves every overflow entry that is now inside the window onto the ring. When nothing is pending anywhere, `idle` is high.

Only one command is taken per cycle. A schedule wins over a pop, and a pop wins over an advance.

Top module: `timing_wheel`

## Requirements
- R1: After reset, `now_time` is 0, `idle` is 1, and `busy`, `pend`, `pop_valid`, `err_late` and `err_full` are all 0. Every signal's current value starts at 0.
- R2: An event with `now_time` ≤ t ≤ `now_time`+SLOTS-1 goes into ring slot t mod SLOTS. It is returned by pops once `now_time` equals t, and `pend` is 1 while such entries remain at the current time.
- R3: An event with t ≥ `now_time`+SLOTS goes to the overflow store. It is moved onto the ring before the advance that reaches its window completes, and it is popped at time t.
- R4: Scheduling at t < `now_time` raises `err_late` in the next cycle and stores nothing.
- R5: A pop takes the oldest entry of the current slot, so entries come out in the order they were placed. `pop_valid`, `pop_id` and `pop_val` appear in the cycle after the request.
- R6: A popped entry whose value equals the signal's current value gives `pop_valid` = 0. Otherwise `pop_valid` = 1. Either way the signal's current value becomes the popped value.
- R7: While the current slot still holds entries (`pend` = 1), `adv` has no effect on `now_time`.
- R8: An accepted advance keeps `busy` high until `now_time` equals the earliest pending event time. `busy` then drops with `pend` = 1, and `now_time` never decreases.
- R9: `idle` is 1 exactly when the ring and the overflow store are both empty. An advance while idle leaves `now_time` unchanged.
- R10: An in-window schedule while all POOL nodes are in use raises `err_full` in the next cycle and is discarded.
- R3b: An out-of-window schedule while all OVF overflow entries are used raises `err_full` in the next cycle and is discarded.
- R11: A pop request while `busy` is 1 returns nothing and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sch_valid | input | 1 | Schedule an event this cycle |
| sch_time | input | TW | Event time |
| sch_id | input | IDW | Signal number |
| sch_val | input | VW | New signal value |
| pop_req | input | 1 | Remove one entry of the current time |
| adv | input | 1 | Move to the next time holding work |
| now_time | output | TW | Current simulated time |
| pend | output | 1 | Current slot holds entries |
| busy | output | 1 | Advance in progress |
| idle | output | 1 | Ring and overflow store empty |
| pop_valid | output | 1 | Popped entry is a real event |
| pop_id | output | IDW | Signal number of popped entry |
| pop_val | output | VW | Value of popped entry |
| err_late | output | 1 | Pulse: schedule in the past rejected |
| err_full | output | 1 | Pulse: schedule rejected for lack of space |

## Verification
Directed patterns come first:
- A run of same-time entries checks the pop order.
- Entries at the last in-window time and at the first out-of-window time show the exact window boundary.
- A lone event far ahead with an empty ring checks the jump over empty windows, and a pop is issued during that advance.
- Filling the node pool and filling the overflow store check each capacity limit separately.

Seeded random batches then mix near, far and late times with random values. Because signal values repeat across times, these batches exercise the split between real events and non-events. A bench model predicts, for each time, which entries must come back valid, and where each advance must land.

// File: rtl/timing_wheel.sv
module timing_wheel #(
  parameter int TW    = 16,
  parameter int IDW   = 4,
  parameter int VW    = 1,
  parameter int SLOTS = 8,
  parameter int POOL  = 32,
  parameter int OVF   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sch_valid,
  input  logic [TW-1:0]  sch_time,
  input  logic [IDW-1:0] sch_id,
  input  logic [VW-1:0]  sch_val,
  input  logic           pop_req,
  input  logic           adv,
  output logic [TW-1:0]  now_time,
  output logic           pend,
  output logic           busy,
  output logic           idle,
  output logic           pop_valid,
  output logic [IDW-1:0] pop_id,
  output logic [VW-1:0]  pop_val,
  output logic           err_late,
  output logic           err_full
);
  localparam int SW   = $clog2(SLOTS);
  localparam int PW   = $clog2(POOL);
  localparam int OW   = $clog2(OVF);
  localparam int NSIG = 1 << IDW;

  logic [TW-1:0]  tc;
  logic           busy_q;
  logic [SLOTS-1:0] sv;
  logic [PW-1:0]  hd [SLOTS];
  logic [PW-1:0]  tl [SLOTS];
  logic [PW-1:0]  nxt [POOL];
  logic [IDW-1:0] e_id [POOL];
  logic [VW-1:0]  e_val [POOL];
  logic [PW-1:0]  free_hd;
  logic [PW:0]    free_cnt, wheel_cnt;
  logic [OVF-1:0] ov_v;
  logic [TW-1:0]  ov_t [OVF];
  logic [IDW-1:0] ov_id [OVF];
  logic [VW-1:0]  ov_val [OVF];
  logic [VW-1:0]  sigv [NSIG];

  logic [SW-1:0]  cur;
  logic [TW-1:0]  sch_dt;
  logic           sch_late, sch_near, do_sch, do_pop, do_adv, pop_go;
  logic           ov_hit, ov_has_free;
  logic [OW-1:0]  ov_hidx, ov_fidx;
  logic [TW-1:0]  ov_min;
  logic           pool_ok, mig_go, ins_go, ovf_go, full_err;
  logic [SW-1:0]  ins_slot;
  logic [IDW-1:0] ins_id;
  logic [VW-1:0]  ins_val;
  logic [PW-1:0]  pnode;

  assign now_time = tc;
  assign busy     = busy_q;
  assign cur      = tc[SW-1:0];
  assign pend     = sv[cur];
  assign idle     = (wheel_cnt == '0) && (ov_v == '0);

  assign sch_dt   = sch_time - tc;
  assign sch_late = sch_time < tc;
  assign sch_near = !sch_late && (sch_dt < TW'(SLOTS));
  assign do_sch   = sch_valid && !busy_q;
  assign do_pop   = pop_req && !sch_valid && !busy_q;
  assign do_adv   = adv && !pop_req && !sch_valid && !busy_q && !pend && !idle;
  assign pop_go   = do_pop && pend;
  assign pnode    = hd[cur];

  always_comb begin
    ov_hit = 1'b0; ov_hidx = '0; ov_has_free = 1'b0; ov_fidx = '0;
    for (int k = OVF - 1; k >= 0; k--) begin
      if (ov_v[k] && ov_t[k] >= tc && (ov_t[k] - tc) < TW'(SLOTS)) begin
        ov_hit = 1'b1; ov_hidx = OW'(k);
      end
      if (!ov_v[k]) begin
        ov_has_free = 1'b1; ov_fidx = OW'(k);
      end
    end
    ov_min = '1;
    for (int k = 0; k < OVF; k++)
      if (ov_v[k] && ov_t[k] < ov_min) ov_min = ov_t[k];
  end

  assign pool_ok  = free_cnt != '0;
  assign mig_go   = busy_q && ov_hit && pool_ok;
  assign ins_go   = mig_go || (do_sch && sch_near && pool_ok);
  assign ins_slot = busy_q ? ov_t[ov_hidx][SW-1:0] : sch_time[SW-1:0];
  assign ins_id   = busy_q ? ov_id[ov_hidx] : sch_id;
  assign ins_val  = busy_q ? ov_val[ov_hidx] : sch_val;
  assign ovf_go   = do_sch && !sch_late && !sch_near && ov_has_free;
  assign full_err = do_sch && !sch_late && (sch_near ? !pool_ok : !ov_has_free);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc <= '0; busy_q <= 1'b0; sv <= '0; free_hd <= '0;
      free_cnt <= (PW+1)'(POOL); wheel_cnt <= '0; ov_v <= '0;
      pop_valid <= 1'b0; pop_id <= '0; pop_val <= '0;
      err_late <= 1'b0; err_full <= 1'b0;
      for (int i = 0; i < SLOTS; i++) begin hd[i] <= '0; tl[i] <= '0; end
      for (int i = 0; i < POOL; i++) begin
        nxt[i] <= PW'((i + 1) % POOL); e_id[i] <= '0; e_val[i] <= '0;
      end
      for (int i = 0; i < OVF; i++) begin ov_t[i] <= '0; ov_id[i] <= '0; ov_val[i] <= '0; end
      for (int i = 0; i < NSIG; i++) sigv[i] <= '0;
    end else begin
      pop_valid <= 1'b0;
      err_late  <= do_sch && sch_late;
      err_full  <= full_err;

      if (ins_go) begin
        free_hd         <= nxt[free_hd];
        e_id[free_hd]   <= ins_id;
        e_val[free_hd]  <= ins_val;
        if (sv[ins_slot]) nxt[tl[ins_slot]] <= free_hd;
        else              hd[ins_slot]      <= free_hd;
        tl[ins_slot]    <= free_hd;
        sv[ins_slot]    <= 1'b1;
        free_cnt        <= free_cnt - 1'b1;
        wheel_cnt       <= wheel_cnt + 1'b1;
      end
      if (mig_go) ov_v[ov_hidx] <= 1'b0;
      if (ovf_go) begin
        ov_v[ov_fidx]   <= 1'b1;
        ov_t[ov_fidx]   <= sch_time;
        ov_id[ov_fidx]  <= sch_id;
        ov_val[ov_fidx] <= sch_val;
      end

      if (pop_go) begin
        hd[cur]   <= nxt[pnode];
        if (tl[cur] == pnode) sv[cur] <= 1'b0;
        nxt[pnode] <= free_hd;
        free_hd    <= pnode;
        free_cnt   <= free_cnt + 1'b1;
        wheel_cnt  <= wheel_cnt - 1'b1;
        pop_valid  <= e_val[pnode] != sigv[e_id[pnode]];
        pop_id     <= e_id[pnode];
        pop_val    <= e_val[pnode];
        sigv[e_id[pnode]] <= e_val[pnode];
      end

      if (do_adv) busy_q <= 1'b1;
      if (busy_q && !mig_go) begin
        if (pend)                                  busy_q <= 1'b0;
        else if (wheel_cnt == '0 && ov_v != '0)    tc <= ov_min;
        else                                       tc <= tc + 1'b1;
      end
    end
  end

  p_time_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tc >= $past(tc)));
  p_adv_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && pend) |=> (tc == $past(tc)));
  p_busy_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> pend);
  p_late_nostore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sch_valid && !busy_q && sch_time < tc) |=> (wheel_cnt == $past(wheel_cnt) && ov_v == $past(ov_v)));
  p_idle_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !pend);
  p_busy_nopop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !pop_valid);
  p_pool_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sch_valid && !busy_q && sch_near && wheel_cnt == (PW+1)'(POOL)) |=> (wheel_cnt == (PW+1)'(POOL)));
endmodule

// File: tb/sim_timing_wheel.sv
`timescale 1ns/1ps
module sim_timing_wheel;
  localparam int TW = 16, IDW = 4, VW = 1, M = 8, POOL = 32, OVF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic sch_valid = 1'b0, pop_req = 1'b0, adv = 1'b0;
  logic [TW-1:0] sch_time = '0;
  logic [IDW-1:0] sch_id = '0;
  logic [VW-1:0] sch_val = '0;
  logic [TW-1:0] now_time;
  logic pend, busy, idle, pop_valid, err_late, err_full;
  logic [IDW-1:0] pop_id;
  logic [VW-1:0] pop_val;

  timing_wheel #(.TW(TW), .IDW(IDW), .VW(VW), .SLOTS(M), .POOL(POOL), .OVF(OVF)) u0 (
    .clk(clk), .rst_n(rst_n), .sch_valid(sch_valid), .sch_time(sch_time), .sch_id(sch_id),
    .sch_val(sch_val), .pop_req(pop_req), .adv(adv), .now_time(now_time), .pend(pend),
    .busy(busy), .idle(idle), .pop_valid(pop_valid), .pop_id(pop_id), .pop_val(pop_val),
    .err_late(err_late), .err_full(err_full));

  int n_run = 0, n_fail = 0;
  int ev_t[64], ev_id[64], ev_v[64];
  bit ev_live[64];
  int msig[16];
  int mt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int n_live();
    int n = 0;
    for (int i = 0; i < 64; i++) if (ev_live[i]) n++;
    return n;
  endfunction

  function automatic int n_side(input bit far);
    int n = 0;
    for (int i = 0; i < 64; i++) if (ev_live[i] && ((ev_t[i] >= mt + M) == far)) n++;
    return n;
  endfunction

  function automatic bit taken(input int t, input int id);
    for (int i = 0; i < 64; i++) if (ev_live[i] && ev_t[i] == t && ev_id[i] == id) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int next_t();
    int b = -1;
    for (int i = 0; i < 64; i++) if (ev_live[i] && (b < 0 || ev_t[i] < b)) b = ev_t[i];
    return b;
  endfunction

  task automatic add_ev(input int t, input int id, input int v);
    for (int i = 0; i < 64; i++)
      if (!ev_live[i]) begin
        ev_live[i] = 1'b1; ev_t[i] = t; ev_id[i] = id; ev_v[i] = v;
        return;
      end
  endtask

  task automatic retire();
    for (int i = 0; i < 64; i++)
      if (ev_live[i] && ev_t[i] == mt) begin msig[ev_id[i]] = ev_v[i]; ev_live[i] = 1'b0; end
  endtask

  task automatic sched(input int t, input int id, input int v, input string req);
    bit late, near, full;
    late = t < mt;
    near = !late && (t - mt) < M;
    full = !late && (near ? n_side(1'b0) >= POOL : n_side(1'b1) >= OVF);
    @(negedge clk);
    sch_valid = 1'b1; sch_time = t[TW-1:0]; sch_id = id[IDW-1:0]; sch_val = v[VW-1:0];
    @(negedge clk);
    sch_valid = 1'b0;
    chk(err_late == late, {req, " err_late"}, int'(err_late), int'(late));
    chk(err_full == full, {req, " err_full"}, int'(err_full), int'(full));
    if (!late && !full) add_ev(t, id, v);
  endtask

  task automatic pop1(output bit v, output int id, output int val);
    @(negedge clk); pop_req = 1'b1;
    @(negedge clk); pop_req = 1'b0;
    v = pop_valid; id = int'(pop_id); val = int'(pop_val);
  endtask

  task automatic drain();
    int n = 0, nexp = 0, ngot = 0, id, val;
    bit v, found;
    bit used[64];
    for (int i = 0; i < 64; i++) begin
      used[i] = 1'b0;
      if (ev_live[i] && ev_t[i] == mt) begin
        n++;
        if (ev_v[i] != msig[ev_id[i]]) nexp++;
      end
    end
    for (int k = 0; k < n; k++) begin
      chk(pend == 1'b1, "R2 pend while entries remain", int'(pend), 1);
      pop1(v, id, val);
      if (v) begin
        found = 1'b0;
        for (int i = 0; i < 64; i++)
          if (!found && ev_live[i] && ev_t[i] == mt && !used[i] && ev_id[i] == id &&
              ev_v[i] == val && val != msig[id]) begin
            used[i] = 1'b1; found = 1'b1;
          end
        chk(found, "R6 popped event matches a real pending change", id, val);
        ngot++;
      end
    end
    chk(pend == 1'b0, "R2 slot empty after drain", int'(pend), 0);
    chk(ngot == nexp, "R6 count of real events at this time", ngot, nexp);
    retire();
  endtask

  task automatic advance(input string req, input bit poke);
    int nt, w;
    nt = next_t();
    @(negedge clk); adv = 1'b1;
    @(negedge clk); adv = 1'b0;
    if (poke && busy) begin
      pop_req = 1'b1;
      @(negedge clk); pop_req = 1'b0;
      chk(pop_valid == 1'b0, "R11 pop ignored while busy", int'(pop_valid), 0);
    end
    w = 0;
    while (busy && w < 2000) begin @(negedge clk); w++; end
    if (nt < 0) begin
      chk(int'(now_time) == mt && !busy, {req, " idle advance keeps time"}, int'(now_time), mt);
    end else begin
      chk(int'(now_time) == nt, {req, " advance lands on next time"}, int'(now_time), nt);
      chk(pend == 1'b1, {req, " pend after advance"}, int'(pend), 1);
      mt = nt;
    end
  endtask

  task automatic run_out(input string req);
    int g = 0;
    drain();
    while (n_live() > 0 && g < 200) begin
      advance(req, 1'b0);
      drain();
      g++;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit v; int id, val, t, r;
    for (int i = 0; i < 64; i++) ev_live[i] = 1'b0;
    for (int i = 0; i < 16; i++) msig[i] = 0;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(now_time == '0, "R1 time after reset", int'(now_time), 0);
    chk(idle == 1'b1, "R1 idle after reset", int'(idle), 1);
    chk(!busy && !pend && !pop_valid, "R1 busy/pend/pop_valid low", int'({busy, pend, pop_valid}), 0);
    chk(!err_late && !err_full, "R1 errors low", int'({err_late, err_full}), 0);

    // R9: advance while idle
    advance("R9", 1'b0);

    // R6: same value as current (0) is dropped, a change is kept
    sched(0, 5, 0, "R6");
    chk(idle == 1'b0, "R9 not idle with a pending entry", int'(idle), 0);
    drain();
    sched(0, 6, 1, "R6");
    drain();

    // R5 ordering and R7 blocked advance
    sched(mt + 2, 1, 1, "R5"); sched(mt + 2, 2, 1, "R5"); sched(mt + 2, 3, 1, "R5");
    advance("R8", 1'b0);
    @(negedge clk); adv = 1'b1;
    @(negedge clk); adv = 1'b0;
    chk(int'(now_time) == mt && !busy, "R7 advance ignored while pend", int'(now_time), mt);
    for (int k = 1; k <= 3; k++) begin
      pop1(v, id, val);
      chk(v && id == k, "R5 pop order", id, k);
    end
    chk(pend == 1'b0, "R5 slot empty after three pops", int'(pend), 0);
    retire();

    // R4 late
    sched(mt - 1, 4, 1, "R4");

    // R2 / R3 window boundary
    sched(mt + 7, 1, 0, "R2");
    sched(mt + 8, 2, 0, "R3");
    advance("R2", 1'b0); drain();
    advance("R3", 1'b0); drain();

    // R3 jump over empty windows, R11 pop during busy
    sched(mt + 100, 7, 1, "R3");
    advance("R3", 1'b1);
    drain();

    // R3b overflow full
    for (int k = 0; k < OVF; k++) sched(mt + 20 + k, k, 1 - msig[k], "R3b");
    sched(mt + 40, 9, 1, "R3b");
    run_out("R3");

    // R10 pool full
    for (int s = 0; s < M; s++)
      for (int q = 0; q < POOL / M; q++) sched(mt + s, q, 1, "R10");
    sched(mt + 1, 12, 1, "R10");
    run_out("R10");

    // random batches
    for (int b = 0; b < 8; b++) begin
      for (int j = 0; j < 14; j++) begin
        r = int'($urandom % 26);
        t = mt + r - 1;
        if (t < 0) t = 0;
        id = int'($urandom % 16);
        val = int'($urandom % 2);
        if (n_live() < 28 && !taken(t, id)) sched(t, id, val, "R2/R3/R4 random");
      end
      run_out("R8");
    end

    advance("R9", 1'b0);
    chk(idle == 1'b1, "R9 idle at end", int'(idle), 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule